// File: doc/BRIEF.md
# Dual Converter Combined Trigger Arbiter

This block sits between two trigger streams and a pair of conversion engines, one designated master (bit 0 of every per-engine vector) and one slave (bit 1). A regular trigger launches the regular sequences of both engines in the same cycle, so they run in lockstep. Priority triggers are handed to one engine at a time, and a rotating pointer moves the next one to the other engine.

A priority trigger can arrive while regular work is under way. The arbiter then freezes regular work on both engines and hands the priority conversion to the engine the pointer names. Further priority triggers are discarded until regular work restarts. When the priority conversion finishes, both engines get a resume strobe together and carry on from where they were frozen. Each engine has a one-cycle completion flag for regular work and another for priority work.

Every output is registered. A strobe therefore appears one clock after the input event that caused it. The engines are outside this block and report back through busy and done inputs.

Top module: `dual_trig_arbiter`

## Requirements
- R1: When the arbiter is idle and neither engine is busy, a regular trigger makes `regStart` equal 2'b11 for exactly one cycle, one clock after the trigger is sampled; `regStart` is never a single-engine value.
- R2: A regular trigger is discarded, with no strobe of any kind, while regular or priority work is outstanding or while either `engBusy` bit is high.
- R3: When idle, a priority trigger gives a one-cycle, one-hot `priStart` on the engine selected by the pointer, one clock later. The pointer comes out of reset selecting the master (2'b01). The trigger is discarded if the selected engine is busy.
- R4: The pointer advances when the selected engine reports done for a priority conversion, so successive served priority triggers alternate 2'b01, 2'b10, 2'b01.
- R5: A priority trigger arriving while regular work is outstanding produces, in one and the same cycle, `regStop` = 2'b11 and a one-hot `priStart` on the pointer-selected engine.
- R6: While a priority conversion is running, whether it pre-empted regular work or started from idle, further priority triggers are discarded and leave the pointer unchanged.
- R7: When a pre-empting priority conversion completes, `regResume` = 2'b11 is raised in the same cycle as that engine's `priEoc` bit.
- R8: `regEoc[i]` pulses for one cycle, one clock after engine i reports done with regular work outstanding. `priEoc[i]` pulses one clock after the selected engine reports done for a priority conversion. A done from an engine with nothing outstanding raises no flag.
- R9: Once both engines have reported regular done, the arbiter returns to idle and accepts new triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regTrig | input | 1 | Regular-group trigger, one-cycle pulse |
| priTrig | input | 1 | Priority-group trigger, one-cycle pulse |
| engBusy | input | 2 | Per-engine busy indication |
| engDone | input | 2 | Per-engine one-cycle done pulse |
| regStart | output | 2 | Start regular sequence strobe |
| regStop | output | 2 | Freeze regular sequence strobe |
| regResume | output | 2 | Continue frozen regular sequence strobe |
| priStart | output | 2 | Start priority conversion strobe |
| regEoc | output | 2 | Regular completion flag per engine |
| priEoc | output | 2 | Priority completion flag per engine |

## Verification
The hardest situation to reach from the ports is a second priority trigger landing inside the pre-emption window. If it were accepted wrongly, it would double-start an engine or shift the alternation pointer unseen. The bench starts regular work and pre-empts it two cycles later, while the engines are still mid-sequence. It then fires another priority trigger and a regular trigger during the short priority conversion. Finally it checks that the next stand-alone priority trigger still lands on the engine that strict alternation predicts.

// File: rtl/dual_arb_pkg.sv
package dual_arb_pkg;
  localparam int NENG = 2;
  localparam int PTRW = (NENG > 1) ? $clog2(NENG) : 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REG,
    ST_PRI_SOLO,
    ST_PRI_PRE
  } arbState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic launchReg;
    logic launchPri;
    logic haltReg;
    logic resumeReg;
    logic flipPtr;
    logic inReg;
    logic inPri;
  } ctlStrobe_t;
endpackage

// File: rtl/dual_arb_ctrl.sv
module dual_arb_ctrl
  import dual_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            regTrig,
  input  logic            priTrig,
  input  logic [NENG-1:0] engBusy,
  input  logic [NENG-1:0] engDone,
  input  logic [NENG-1:0] regActive,
  input  logic [NENG-1:0] ptrOneHot,
  output ctlStrobe_t      ctl
);
  arbState_t state, stateNxt;
  logic [NENG-1:0] regLeft;
  logic priDoneSel;

  assign regLeft    = regActive & ~engDone;
  assign priDoneSel = |(engDone & ptrOneHot);

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (regTrig && (engBusy == '0)) begin
          ctl.launchReg = 1'b1;
          stateNxt      = ST_REG;
        end else if (priTrig && ((engBusy & ptrOneHot) == '0)) begin
          ctl.launchPri = 1'b1;
          stateNxt      = ST_PRI_SOLO;
        end
      end
      ST_REG: begin
        ctl.inReg = 1'b1;
        if (priTrig && (regLeft != '0)) begin
          ctl.haltReg   = 1'b1;
          ctl.launchPri = 1'b1;
          stateNxt      = ST_PRI_PRE;
        end else if (regLeft == '0) begin
          stateNxt = ST_IDLE;
        end
      end
      ST_PRI_SOLO: begin
        ctl.inPri = 1'b1;
        if (priDoneSel) begin
          ctl.flipPtr = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      ST_PRI_PRE: begin
        ctl.inPri = 1'b1;
        if (priDoneSel) begin
          ctl.flipPtr   = 1'b1;
          ctl.resumeReg = 1'b1;
          stateNxt      = ST_REG;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/dual_arb_dpath.sv
module dual_arb_dpath
  import dual_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      ctl,
  input  logic [NENG-1:0] engDone,
  output logic [NENG-1:0] regActive,
  output logic [NENG-1:0] ptrOneHot,
  output logic [NENG-1:0] regStart,
  output logic [NENG-1:0] regStop,
  output logic [NENG-1:0] regResume,
  output logic [NENG-1:0] priStart,
  output logic [NENG-1:0] regEoc,
  output logic [NENG-1:0] priEoc
);
  logic [PTRW-1:0] ptrIdx;

  assign ptrOneHot = NENG'(1) << ptrIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrIdx    <= '0;
      regActive <= '0;
      regStart  <= '0;
      regStop   <= '0;
      regResume <= '0;
      priStart  <= '0;
      regEoc    <= '0;
      priEoc    <= '0;
    end else begin
      regStart  <= ctl.launchReg ? '1 : '0;
      regStop   <= ctl.haltReg   ? '1 : '0;
      regResume <= ctl.resumeReg ? '1 : '0;
      priStart  <= ctl.launchPri ? ptrOneHot : '0;
      regEoc    <= ctl.inReg ? (engDone & regActive) : '0;
      priEoc    <= ctl.inPri ? (engDone & ptrOneHot) : '0;
      if (ctl.launchReg)  regActive <= '1;
      else if (ctl.inReg) regActive <= regActive & ~engDone;
      if (ctl.flipPtr)
        ptrIdx <= (ptrIdx == PTRW'(NENG - 1)) ? '0 : ptrIdx + 1'b1;
    end
  end
endmodule

// File: rtl/dual_trig_arbiter.sv
module dual_trig_arbiter
  import dual_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            regTrig,
  input  logic            priTrig,
  input  logic [NENG-1:0] engBusy,
  input  logic [NENG-1:0] engDone,
  output logic [NENG-1:0] regStart,
  output logic [NENG-1:0] regStop,
  output logic [NENG-1:0] regResume,
  output logic [NENG-1:0] priStart,
  output logic [NENG-1:0] regEoc,
  output logic [NENG-1:0] priEoc
);
  ctlStrobe_t ctl;
  logic [NENG-1:0] regActive;
  logic [NENG-1:0] ptrOneHot;

  dual_arb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regTrig(regTrig), .priTrig(priTrig),
    .engBusy(engBusy), .engDone(engDone), .regActive(regActive),
    .ptrOneHot(ptrOneHot), .ctl(ctl)
  );

  dual_arb_dpath dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .engDone(engDone),
    .regActive(regActive), .ptrOneHot(ptrOneHot),
    .regStart(regStart), .regStop(regStop), .regResume(regResume),
    .priStart(priStart), .regEoc(regEoc), .priEoc(priEoc)
  );
endmodule

// File: rtl/dual_trig_arbiter_chk.sv
module dual_trig_arbiter_chk
  import dual_arb_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            regTrig,
  input logic            priTrig,
  input logic [NENG-1:0] engBusy,
  input logic [NENG-1:0] engDone,
  input logic [NENG-1:0] regStart,
  input logic [NENG-1:0] regStop,
  input logic [NENG-1:0] regResume,
  input logic [NENG-1:0] priStart,
  input logic [NENG-1:0] regEoc,
  input logic [NENG-1:0] priEoc
);
  logic preempted;
  logic seenPri;
  logic [NENG-1:0] lastPri;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preempted <= 1'b0;
      seenPri   <= 1'b0;
      lastPri   <= '0;
    end else begin
      if (regStop != '0)        preempted <= 1'b1;
      else if (regResume != '0) preempted <= 1'b0;
      if (priStart != '0) begin
        seenPri <= 1'b1;
        lastPri <= priStart;
      end
    end
  end

  assert_reg_lockstep_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regStart == '0) || (regStart == '1));

  assert_pri_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(priStart));

  assert_pri_alternate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (seenPri && (priStart != '0)) |-> (priStart != lastPri));

  assert_preempt_pair_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regStop != '0) |-> ((regStop == '1) && ($countones(priStart) == 1)));

  assert_no_start_while_preempted_R6: assert property (@(posedge clk) disable iff (!rstN)
    preempted |-> (priStart == '0));

  assert_resume_with_eoc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regResume != '0) |-> ((regResume == '1) && ($countones(priEoc) == 1)));

  assert_flags_disjoint_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regEoc & priEoc) == '0);
endmodule

bind dual_trig_arbiter dual_trig_arbiter_chk chk_i (.*);

// File: tb/dual_trig_arbiter_tb.sv
module dual_trig_arbiter_tb_top;
  localparam int REG_LAT = 12;
  localparam int PRI_LAT = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regTrig = 1'b0;
  logic priTrig = 1'b0;
  logic [1:0] engBusy;
  logic [1:0] engDone = 2'b00;
  logic [1:0] forceBusy = 2'b00;
  logic [1:0] regStart, regStop, regResume, priStart, regEoc, priEoc;

  int nChecks = 0;
  int nFails = 0;
  logic [11:0] expVec[$];
  string expTag[$];

  always #2 clk = ~clk;

  dual_trig_arbiter dut_i (
    .clk(clk), .rstN(rstN), .regTrig(regTrig), .priTrig(priTrig),
    .engBusy(engBusy), .engDone(engDone), .regStart(regStart),
    .regStop(regStop), .regResume(regResume), .priStart(priStart),
    .regEoc(regEoc), .priEoc(priEoc)
  );

  // fixed-latency engine models
  int  regCnt[2];
  int  priCnt[2];
  bit  regRun[2];
  bit  priRun[2];
  bit  frozen[2];

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      engDone[i] <= 1'b0;
      if (!rstN) begin
        regRun[i] <= 0; priRun[i] <= 0; frozen[i] <= 0;
        regCnt[i] <= 0; priCnt[i] <= 0;
      end else begin
        if (regStart[i]) begin
          regRun[i] <= 1; frozen[i] <= 0; regCnt[i] <= REG_LAT;
        end else if (regStop[i]) begin
          frozen[i] <= 1;
        end else if (regResume[i]) begin
          frozen[i] <= 0;
        end else if (regRun[i] && !frozen[i]) begin
          if (regCnt[i] == 1) begin regRun[i] <= 0; engDone[i] <= 1'b1; end
          else regCnt[i] <= regCnt[i] - 1;
        end
        if (priStart[i]) begin
          priRun[i] <= 1; priCnt[i] <= PRI_LAT;
        end else if (priRun[i]) begin
          if (priCnt[i] == 1) begin priRun[i] <= 0; engDone[i] <= 1'b1; end
          else priCnt[i] <= priCnt[i] - 1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < 2; i++)
      engBusy[i] = regRun[i] | priRun[i] | forceBusy[i];
  end

  function automatic logic [11:0] mk(input logic [1:0] rs, input logic [1:0] rp,
      input logic [1:0] rr, input logic [1:0] ps, input logic [1:0] re, input logic [1:0] pe);
    return {rs, rp, rr, ps, re, pe};
  endfunction

  task automatic expect_item(input logic [11:0] v, input string tag);
    expVec.push_back(v);
    expTag.push_back(tag);
  endtask

  task automatic pulse_reg();
    @(negedge clk); regTrig = 1'b1;
    @(negedge clk); regTrig = 1'b0;
  endtask

  task automatic pulse_pri();
    @(negedge clk); priTrig = 1'b1;
    @(negedge clk); priTrig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every output event against the queue head
  always @(negedge clk) begin
    logic [11:0] obs;
    obs = {regStart, regStop, regResume, priStart, regEoc, priEoc};
    if (rstN && obs != 12'h000) begin
      nChecks++;
      if (expVec.size() == 0) begin
        nFails++;
        $display("FAIL unexpected event (R2/R6 discard) actual=%b expected=none", obs);
      end else begin
        logic [11:0] ev;
        string tg;
        ev = expVec.pop_front();
        tg = expTag.pop_front();
        if (obs !== ev) begin
          nFails++;
          $display("FAIL %s actual=%b expected=%b", tg, obs, ev);
        end
      end
    end
  end

  bit finished = 0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(4);
    nChecks++;
    if ({regStart, regStop, regResume, priStart, regEoc, priEoc} !== 12'h000) begin
      nFails++;
      $display("FAIL reset outputs actual=%b expected=0",
               {regStart, regStop, regResume, priStart, regEoc, priEoc});
    end
    rstN = 1'b1;
    idle(2);

    // R1, R8, R9: lockstep regular start and completion; R2: retrigger ignored
    expect_item(mk(2'b11, 0, 0, 0, 0, 0), "R1 regular start both");
    expect_item(mk(0, 0, 0, 0, 2'b11, 0), "R8 regular eoc both");
    pulse_reg();
    idle(3);
    pulse_reg();
    idle(20);

    // R3, R4: idle priority alternates, starting at master
    expect_item(mk(0, 0, 0, 2'b01, 0, 0), "R3 priority to master");
    expect_item(mk(0, 0, 0, 0, 0, 2'b01), "R8 priority eoc master");
    pulse_pri();
    idle(10);
    expect_item(mk(0, 0, 0, 2'b10, 0, 0), "R4 priority to slave");
    expect_item(mk(0, 0, 0, 0, 0, 2'b10), "R8 priority eoc slave");
    pulse_pri();
    idle(10);

    // R2, R3: busy engine blocks triggers
    forceBusy = 2'b01;
    pulse_reg();
    pulse_pri();
    idle(4);
    forceBusy = 2'b00;
    idle(2);

    // R5, R6, R7, R9: pre-emption of regular work
    expect_item(mk(2'b11, 0, 0, 0, 0, 0), "R9 regular restart");
    expect_item(mk(0, 2'b11, 0, 2'b01, 0, 0), "R5 halt and priority master");
    expect_item(mk(0, 0, 2'b11, 0, 0, 2'b01), "R7 resume with eoc");
    expect_item(mk(0, 0, 0, 0, 2'b11, 0), "R8 regular eoc after resume");
    pulse_reg();
    idle(2);
    pulse_pri();
    idle(1);
    pulse_pri();
    pulse_reg();
    idle(30);

    // R4, R6: pointer advanced exactly once; trigger during solo priority ignored
    expect_item(mk(0, 0, 0, 2'b10, 0, 0), "R6 pointer at slave");
    expect_item(mk(0, 0, 0, 0, 0, 2'b10), "R8 priority eoc slave");
    pulse_pri();
    pulse_pri();
    idle(10);
    expect_item(mk(0, 0, 0, 2'b01, 0, 0), "R4 pointer back at master");
    expect_item(mk(0, 0, 0, 0, 0, 2'b01), "R8 priority eoc master");
    pulse_pri();
    idle(10);

    nChecks++;
    if (expVec.size() != 0) begin
      nFails++;
      $display("FAIL missing events (R1-related queue) actual=%0d expected=0 pending",
               expVec.size());
    end
    finish_run();
  end
endmodule